// File: doc/BRIEF.md
# Single-Precision Floating-Point Multiplier

This block multiplies two 32-bit binary floating-point operands (1 sign bit, 8-bit biased exponent with bias 127, 23-bit fraction) and returns a 32-bit product in the same format. A one-cycle `start_i` pulse captures both operands. The block first decodes each operand as zero, normal, infinity or NaN. Any combination involving a zero, an infinity or a NaN is resolved directly, without running the arithmetic, and the result appears one cycle later.

When both operands are normal, the unbiased exponents are added while a sequential shift-add unit multiplies the two 24-bit significands (hidden one included) into a 48-bit product. That unit retires one multiplier bit per cycle. The product lies in [1,4). A single right shift normalises it, and it is then rounded to nearest, ties to even. Denormal inputs are treated as zeros, and results too small for a normal encoding are flushed to zero.

The result is held on `result_o` until the next operation completes. `done_o` is high for the one cycle in which a fresh result first appears.

Top module: `fp32_mul`

## Requirements
- R1: For every result that is not NaN, the sign bit (bit 31) equals the XOR of the two operand sign bits.
- R2: For two normal operands, the result exponent field is E1 + E2 - 127, plus one when the 48-bit significand product is at least 2. The 24-bit kept significand is rounded to nearest, with ties going to the even value.
- R3: When rounding carries out of the 24-bit significand, the significand becomes 1.0 and the exponent field is incremented once more.
- R4: A final exponent field of 255 or more, after normalisation and rounding, gives a signed infinity (exponent field 0xFF, fraction 0).
- R5: A final exponent field of 0 or less gives a signed zero. Any operand with exponent field 0 and a nonzero fraction (a denormal) is treated as a zero of its sign.
- R6: A zero operand multiplied by a finite operand gives a zero with the XOR sign. This result does not use the significand multiplier.
- R7: A NaN operand (exponent 0xFF, fraction nonzero), or a zero multiplied by an infinity in either order and with any signs, gives the single NaN encoding 0x7FC00000.
- R8: An infinity multiplied by a nonzero finite value or by an infinity gives an infinity with the XOR sign.
- R9: `done_o` rises exactly 1 clock edge after the accepting edge for a special-case operation, and exactly 26 edges after it for two normal operands. `done_o` lasts one cycle, and `result_o` holds its value until the next completion.
- R10: `start_i` is ignored while `busy_o` is high. The running operation completes with its own result and latency.
- R11: Under reset, `done_o` and `busy_o` are 0 and `result_o` is 0x00000000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a multiplication with the current operands |
| a_i | input | 32 | First operand |
| b_i | input | 32 | Second operand |
| busy_o | output | 1 | Significand multiplication in progress |
| done_o | output | 1 | One-cycle pulse: new result on result_o |
| result_o | output | 32 | Product, held until the next completion |

## Verification
The bench targets rounding cases where the bits below the kept significand are exactly one half with odd and with even kept values, just under one half, and enough to carry out of the significand. A wrong tie rule shifts the last fraction bit by one. A missed carry leaves an all-ones fraction where 2.0 is expected. Exponents at 254/255 and 1/0 probe overflow and flush-to-zero, including a case that overflows only through rounding; an off-by-one limit there leaks a large finite value or a tiny normal. The special-operand matrix (signed zeros, denormals, infinities, signalling and quiet NaNs, zero times infinity) and a start pulse issued during a busy period catch the wrong sign, a wrong NaN code, a special case that runs the multiplier, or a second operation that corrupts the first.

// File: rtl/fpm_pkg.sv
package fpm_pkg;

  typedef enum logic [1:0] {
    CLS_ZERO = 2'd0,
    CLS_NORM = 2'd1,
    CLS_INF  = 2'd2,
    CLS_NAN  = 2'd3
  } fp_cls_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_MUL  = 1'b1
  } mul_state_e;

endpackage

// File: rtl/fpm_classify.sv
module fpm_classify
  import fpm_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  localparam int OP_W  = 1 + EXP_W + FRAC_W,
  localparam int SIG_W = FRAC_W + 1
) (
  input  logic [OP_W-1:0]  op_i,
  output fp_cls_e          cls_o,
  output logic [EXP_W-1:0] exp_o,
  output logic [SIG_W-1:0] sig_o
);

  logic [FRAC_W-1:0] frac;

  assign exp_o = op_i[OP_W-2 -: EXP_W];
  assign frac  = op_i[FRAC_W-1:0];
  assign sig_o = {1'b1, frac};

  // denormals fall into the zero class (flush-to-zero on input)
  always_comb begin
    if (exp_o == '0)      cls_o = CLS_ZERO;
    else if (&exp_o)      cls_o = (frac != '0) ? CLS_NAN : CLS_INF;
    else                  cls_o = CLS_NORM;
  end

endmodule

// File: rtl/fpm_sig_mul.sv
module fpm_sig_mul #(
  parameter int W   = 24,
  localparam int CW = $clog2(W)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           start_i,
  input  logic [W-1:0]   mcand_i,
  input  logic [W-1:0]   mplier_i,
  output logic           busy_o,
  output logic           done_o,
  output logic [2*W-1:0] prod_o
);

  logic [W-1:0]  hi_q, lo_q, mcand_q;
  logic [CW-1:0] cnt_q;
  logic          busy_q, done_q;

  logic [W:0]     part_sum;
  logic [2*W:0]   shifted;

  // one multiplier bit per cycle: add, then shift the whole accumulator right
  assign part_sum = {1'b0, hi_q} + (lo_q[0] ? {1'b0, mcand_q} : '0);
  assign shifted  = {part_sum, lo_q} >> 1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_q    <= '0;
      lo_q    <= '0;
      mcand_q <= '0;
      cnt_q   <= '0;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (busy_q) begin
        hi_q  <= shifted[2*W-1:W];
        lo_q  <= shifted[W-1:0];
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == CW'(W-1)) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end else if (start_i) begin
        hi_q    <= '0;
        lo_q    <= mplier_i;
        mcand_q <= mcand_i;
        cnt_q   <= '0;
        busy_q  <= 1'b1;
      end
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;
  assign prod_o = {hi_q, lo_q};

  assert_cnt_range_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> (cnt_q <= CW'(W-1)));

  assert_done_single_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);

  assert_done_after_busy_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_q) |-> done_q);

endmodule

// File: rtl/fpm_round.sv
module fpm_round #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  localparam int OP_W  = 1 + EXP_W + FRAC_W,
  localparam int SW    = FRAC_W + 1,
  localparam int PW    = 2 * SW,
  localparam int EW2   = EXP_W + 2
) (
  input  logic                  sign_i,
  input  logic signed [EW2-1:0] exp_sum_i,
  input  logic [PW-1:0]         prod_i,
  output logic [OP_W-1:0]       result_o
);

  localparam logic signed [EW2-1:0] EMAX_S = EW2'((1 << EXP_W) - 1);

  logic          hi;
  logic [SW-1:0] kept;
  logic          guard, sticky, rnd_up, carry;
  logic [SW:0]   rsum;
  logic [SW-1:0] mant;
  logic signed [EW2-1:0] exp_adj;

  assign hi     = prod_i[PW-1];
  assign kept   = hi ? prod_i[PW-1 -: SW] : prod_i[PW-2 -: SW];
  assign guard  = hi ? prod_i[PW-1-SW]    : prod_i[PW-2-SW];
  assign sticky = hi ? (|prod_i[PW-2-SW:0]) : (|prod_i[PW-3-SW:0]);
  assign rnd_up = guard & (sticky | kept[0]);
  assign rsum   = {1'b0, kept} + {{SW{1'b0}}, rnd_up};
  assign carry  = rsum[SW];
  assign mant   = carry ? rsum[SW:1] : rsum[SW-1:0];

  assign exp_adj = exp_sum_i
                 + $signed({{(EW2-1){1'b0}}, hi})
                 + $signed({{(EW2-1){1'b0}}, carry});

  always_comb begin
    if (exp_adj >= EMAX_S)
      result_o = {sign_i, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
    else if (exp_adj[EW2-1] || exp_adj == '0)
      result_o = {sign_i, {(OP_W-1){1'b0}}};
    else
      result_o = {sign_i, exp_adj[EXP_W-1:0], mant[FRAC_W-1:0]};
  end

  // a product of two normals keeps its leading one after rounding
  always_comb begin
    if (prod_i[PW-1:PW-2] != 2'b00)
      assert_norm_lead_R2: assert (mant[SW-1]);
  end

endmodule

// File: rtl/fp32_mul.sv
module fp32_mul
  import fpm_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  localparam int OP_W  = 1 + EXP_W + FRAC_W,
  localparam int SIG_W = FRAC_W + 1,
  localparam int EW2   = EXP_W + 2,
  localparam int BIAS  = (1 << (EXP_W - 1)) - 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic [OP_W-1:0] a_i,
  input  logic [OP_W-1:0] b_i,
  output logic            busy_o,
  output logic            done_o,
  output logic [OP_W-1:0] result_o
);

  localparam logic [OP_W-1:0] QNAN =
    {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

  fp_cls_e          cls_a, cls_b;
  logic [EXP_W-1:0] exp_a, exp_b;
  logic [SIG_W-1:0] sig_a, sig_b;

  fpm_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls_a (
    .op_i(a_i), .cls_o(cls_a), .exp_o(exp_a), .sig_o(sig_a));
  fpm_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls_b (
    .op_i(b_i), .cls_o(cls_b), .exp_o(exp_b), .sig_o(sig_b));

  mul_state_e           st_q;
  logic                 sign_q, done_q;
  logic                 sa_q, sb_q;
  logic signed [EW2-1:0] exp_sum_q;
  logic [OP_W-1:0]      result_q;

  logic sign_d, accept, nan_res, inf_res, zero_res, special;
  logic signed [EW2-1:0] exp_sum_d;
  logic [OP_W-1:0] spec_val;

  assign sign_d = a_i[OP_W-1] ^ b_i[OP_W-1];
  assign accept = start_i && (st_q == ST_IDLE);

  always_comb begin
    nan_res  = (cls_a == CLS_NAN) || (cls_b == CLS_NAN)
            || (cls_a == CLS_ZERO && cls_b == CLS_INF)
            || (cls_a == CLS_INF  && cls_b == CLS_ZERO);
    inf_res  = !nan_res && (cls_a == CLS_INF || cls_b == CLS_INF);
    zero_res = !nan_res && (cls_a == CLS_ZERO || cls_b == CLS_ZERO);
    special  = nan_res || inf_res || zero_res;
    if (nan_res)      spec_val = QNAN;
    else if (inf_res) spec_val = {sign_d, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
    else              spec_val = {sign_d, {(OP_W-1){1'b0}}};
  end

  assign exp_sum_d = $signed({2'b00, exp_a}) + $signed({2'b00, exp_b})
                   - $signed(EW2'(BIAS));

  logic              mul_busy, mul_done;
  logic [2*SIG_W-1:0] mul_prod;
  logic [OP_W-1:0]   rounded;

  fpm_sig_mul #(.W(SIG_W)) u_sig_mul (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (accept && !special),
    .mcand_i  (sig_a),
    .mplier_i (sig_b),
    .busy_o   (mul_busy),
    .done_o   (mul_done),
    .prod_o   (mul_prod)
  );

  fpm_round #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_round (
    .sign_i    (sign_q),
    .exp_sum_i (exp_sum_q),
    .prod_i    (mul_prod),
    .result_o  (rounded)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      sign_q    <= 1'b0;
      sa_q      <= 1'b0;
      sb_q      <= 1'b0;
      exp_sum_q <= '0;
      result_q  <= '0;
      done_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (accept) begin
          sign_q    <= sign_d;
          sa_q      <= a_i[OP_W-1];
          sb_q      <= b_i[OP_W-1];
          exp_sum_q <= exp_sum_d;
          if (special) begin
            result_q <= spec_val;
            done_q   <= 1'b1;
          end else begin
            st_q <= ST_MUL;
          end
        end
        ST_MUL: if (mul_done) begin
          result_q <= rounded;
          done_q   <= 1'b1;
          st_q     <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o   = (st_q == ST_MUL);
  assign done_o   = done_q;
  assign result_o = result_q;

  assert_busy_no_done_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !done_o);

  assert_mul_idle_special_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && special) |=> !mul_busy);

  assert_nan_canon_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && (&result_o[OP_W-2 -: EXP_W]) && result_o[FRAC_W-1:0] != '0)
      |-> result_o == QNAN);

  assert_sign_xor_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && result_o != QNAN) |-> result_o[OP_W-1] == (sa_q ^ sb_q));

  assert_inf_result_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && inf_res) |=> (done_o && (&result_o[OP_W-2 -: EXP_W])
                             && result_o[FRAC_W-1:0] == '0));

endmodule

// File: tb/fp32_mul_tb.sv
module fp32_mul_tb;

  localparam int CLK_PERIOD = 10;
  localparam int LAT_NORM   = 26;
  localparam int LAT_SPEC   = 1;
  localparam int WATCHDOG   = 100000;

  typedef struct packed {
    logic [3:0]  req;
    logic        spec;
    logic [31:0] a;
    logic [31:0] b;
    logic [31:0] expv;
  } vec_t;

  localparam int NV = 26;
  localparam vec_t VEC [NV] = '{
    '{4'd2,  1'b0, 32'h3F800000, 32'h3F800000, 32'h3F800000},
    '{4'd2,  1'b0, 32'h40000000, 32'h40400000, 32'h40C00000},
    '{4'd1,  1'b0, 32'hBFC00000, 32'h40000000, 32'hC0400000},
    '{4'd2,  1'b0, 32'h3FC00000, 32'h3FC00000, 32'h40100000},
    '{4'd2,  1'b0, 32'h3F800001, 32'h3FC00000, 32'h3FC00002},
    '{4'd2,  1'b0, 32'h3F800003, 32'h3FC00000, 32'h3FC00004},
    '{4'd2,  1'b0, 32'h3F800001, 32'h3F800001, 32'h3F800002},
    '{4'd3,  1'b0, 32'h3FFFFFFE, 32'h3F800001, 32'h40000000},
    '{4'd4,  1'b0, 32'h7F000000, 32'h40000000, 32'h7F800000},
    '{4'd4,  1'b0, 32'hFF000000, 32'h40000000, 32'hFF800000},
    '{4'd4,  1'b0, 32'h7F7FFFFF, 32'h3F800001, 32'h7F800000},
    '{4'd2,  1'b0, 32'h7F7FFFFF, 32'h3F800000, 32'h7F7FFFFF},
    '{4'd5,  1'b0, 32'h00800000, 32'h3F000000, 32'h00000000},
    '{4'd5,  1'b0, 32'h80800000, 32'h3F000000, 32'h80000000},
    '{4'd2,  1'b0, 32'h00800000, 32'h3F800000, 32'h00800000},
    '{4'd6,  1'b1, 32'h00000000, 32'h40400000, 32'h00000000},
    '{4'd6,  1'b1, 32'h80000000, 32'h40400000, 32'h80000000},
    '{4'd5,  1'b1, 32'h00000001, 32'h40400000, 32'h00000000},
    '{4'd5,  1'b1, 32'h00400000, 32'hC0000000, 32'h80000000},
    '{4'd7,  1'b1, 32'h00000000, 32'h7F800000, 32'h7FC00000},
    '{4'd7,  1'b1, 32'h7F800000, 32'h80000000, 32'h7FC00000},
    '{4'd7,  1'b1, 32'h7FC12345, 32'h3F800000, 32'h7FC00000},
    '{4'd7,  1'b1, 32'h7F800001, 32'hFF800000, 32'h7FC00000},
    '{4'd8,  1'b1, 32'h7F800000, 32'hC0000000, 32'hFF800000},
    '{4'd8,  1'b1, 32'hFF800000, 32'hFF800000, 32'h7F800000},
    '{4'd1,  1'b0, 32'hC0000000, 32'hC0400000, 32'h40C00000}
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [31:0] a_i = '0;
  logic [31:0] b_i = '0;
  logic        busy_o, done_o;
  logic [31:0] result_o;

  int n_checks = 0;
  int n_fail   = 0;

  fp32_mul u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i),
    .a_i(a_i), .b_i(b_i),
    .busy_o(busy_o), .done_o(done_o), .result_o(result_o)
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  function automatic string req_name(input logic [3:0] r);
    case (r)
      4'd1:    return "R1";
      4'd2:    return "R2";
      4'd3:    return "R3";
      4'd4:    return "R4";
      4'd5:    return "R5";
      4'd6:    return "R6";
      4'd7:    return "R7";
      4'd8:    return "R8";
      default: return "R?";
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] expv);
    n_checks++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, expv);
    end
  endtask

  task automatic run_op(input logic [31:0] a, input logic [31:0] b,
                        output logic [31:0] res, output int lat);
    @(negedge clk_i);
    a_i = a; b_i = b; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    lat = 1;
    while (!done_o && lat < 200) begin
      @(negedge clk_i);
      lat++;
    end
    res = result_o;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk_i);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    logic [31:0] res;
    int lat;

    repeat (3) @(negedge clk_i);
    // R11: reset state
    check("R11 done", {31'd0, done_o}, 32'd0);
    check("R11 busy", {31'd0, busy_o}, 32'd0);
    check("R11 result", result_o, 32'h00000000);
    rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      run_op(VEC[i].a, VEC[i].b, res, lat);
      check(req_name(VEC[i].req), res, VEC[i].expv);
      // R9: latency depends on the operand class
      check("R9 latency", 32'(lat), VEC[i].spec ? 32'(LAT_SPEC) : 32'(LAT_NORM));
    end

    // extra NaN with zero partner
    run_op(32'h7FC00000, 32'h80000000, res, lat);
    check("R7 nan*zero", res, 32'h7FC00000);

    // R9: done lasts one cycle, result held
    run_op(32'h40000000, 32'h40400000, res, lat);
    @(negedge clk_i);
    check("R9 done pulse", {31'd0, done_o}, 32'd0);
    repeat (3) @(negedge clk_i);
    check("R9 result held", result_o, 32'h40C00000);

    // R10: start while busy is ignored
    @(negedge clk_i);
    a_i = 32'h3FC00000; b_i = 32'h3FC00000; start_i = 1'b1;
    @(negedge clk_i);
    check("R10 busy high", {31'd0, busy_o}, 32'd1);
    lat = 1;
    while (!done_o && lat < 200) begin
      if (lat < 6) begin
        start_i = 1'b1; a_i = 32'h00000000; b_i = 32'h80000000;
      end else begin
        start_i = 1'b0;
      end
      @(negedge clk_i);
      lat++;
    end
    start_i = 1'b0;
    check("R10 latency", 32'(lat), 32'(LAT_NORM));
    check("R10 result", result_o, 32'h40100000);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule